// File: doc/BRIEF.md
# Masked Performance Counter Clear

This block holds a bank of 64-bit performance counters: a configurable number of event counters (1 to 31), one cycle counter and an optional instruction counter. Each counter advances by one on a clock edge when its own enable is high and its event input is high. The cycle counter has only an enable, so it advances on every cycle in which that enable is high.

A single 64-bit write-only control word zeroes any chosen subset of the counters at once. The bit position in the word selects the counter. A write takes effect on the clock edge where it is presented. A write is accepted only when the write strobe is high and the permission input from an external access checker is also high. All counter values are visible on read ports at all times.

Top module: `pmc_masked_clear_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every counter is set to zero.
- R2: Event counter m goes up by exactly 1 after an edge where `evt_en[m]` and `evt_in[m]` are both high and no clear selects it. Otherwise it keeps its value.
- R3: The cycle counter goes up by 1 after each edge where `cyc_en` is high and no clear selects it.
- R4: When `HAS_INSTR` is 1, the instruction counter goes up by 1 after an edge where `instr_en` and `instr_in` are both high. When `HAS_INSTR` is 0, `instr_cnt` always reads 0.
- R5: An accepted write with mask bit m set (m from 0 to 30, m < `NUM_EVT`) makes event counter m read 0 after that edge.
- R6: An accepted write with mask bit 31 set makes the cycle counter read 0 after that edge.
- R7: An accepted write with mask bit 32 set makes the instruction counter read 0 after that edge, when that counter is implemented.
- R8: Mask bits 63 to 33, event bits at or above `NUM_EVT`, and bit 32 when `HAS_INSTR` is 0 have no effect on any counter.
- R9: A counter whose mask bit is 0 in an accepted write behaves as if no write occurred.
- R10: A write is accepted only when `wr_en` and `wr_allowed` are both high at the edge. Otherwise the mask is ignored.
- R11: When a clear and an increment reach the same counter at the same edge, the counter reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the clear word |
| wr_allowed | input | 1 | Permission from the access checker |
| wr_mask | input | 64 | Clear word: bit m = event counter m, bit 31 = cycle, bit 32 = instruction, bits 63:33 reserved |
| evt_en | input | NUM_EVT | Per-event-counter enable |
| evt_in | input | NUM_EVT | Per-event-counter event pulse |
| cyc_en | input | 1 | Cycle counter enable |
| instr_en | input | 1 | Instruction counter enable |
| instr_in | input | 1 | Instruction retired pulse |
| evt_cnt | output | NUM_EVT*64 | Event counter values, counter m at bits [64m+63:64m] |
| cyc_cnt | output | 64 | Cycle counter value |
| instr_cnt | output | 64 | Instruction counter value (0 if not implemented) |

## Verification
On every cycle, the assertions check the following:
- Within each counter: clear wins over increment, an idle counter holds its value, and an increment adds exactly one.
- In the decoder: nothing is selected unless the write is both strobed and permitted, and a word with only reserved bits set selects nothing.

Some behaviours only the bench scenarios can show, because they compare counters against an independent model across random mixes of events and masks:
- Bits for event counters that are not implemented leave the whole bank untouched.
- A counter whose mask bit is clear keeps counting through another counter's clear.
- Bit 32 has no effect on a bank built without the instruction counter.

// File: rtl/pmc_clr_pkg.sv
package pmc_clr_pkg;
    localparam int CNT_W     = 64;
    localparam int MASK_W    = 64;
    localparam int MAX_EVT   = 31;
    localparam int CYC_BIT   = 31;
    localparam int INSTR_BIT = 32;

    // Counters picked out by one accepted clear word
    typedef struct packed {
        logic               instr;
        logic               cyc;
        logic [MAX_EVT-1:0] evt;
    } clr_sel_t;

    // Ones for implemented event counters, zeros above
    function automatic logic [MAX_EVT-1:0] evt_keep_mask(input int n);
        logic [MAX_EVT-1:0] m;
        for (int i = 0; i < MAX_EVT; i++) m[i] = (i < n);
        return m;
    endfunction
endpackage

// File: rtl/pmc_clr_decode.sv
module pmc_clr_decode
    import pmc_clr_pkg::*;
#(
    parameter int NUM_EVT   = 31,
    parameter bit HAS_INSTR = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_allowed,
    input  logic [MASK_W-1:0] wr_mask,
    output clr_sel_t          clr
);
    localparam logic [MAX_EVT-1:0] KEEP = evt_keep_mask(NUM_EVT);

    logic accept;
    logic unused_reserved;

    assign accept          = wr_en & wr_allowed;
    assign unused_reserved = ^wr_mask[MASK_W-1:INSTR_BIT+1];

    always_comb begin
        clr       = '0;
        if (accept) begin
            clr.evt   = wr_mask[MAX_EVT-1:0] & KEEP;
            clr.cyc   = wr_mask[CYC_BIT];
            clr.instr = HAS_INSTR & wr_mask[INSTR_BIT];
        end
    end

    assert_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_allowed) |-> (clr == '0));

    assert_reserved_only_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_mask[INSTR_BIT:0] == '0) |-> (clr == '0));
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
    import pmc_clr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             evt,
    output logic [CNT_W-1:0] cnt
);
    logic inc;
    assign inc = en & evt;

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + CNT_W'(1);
    end

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(cnt));

    assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/pmc_masked_clear_bank.sv
module pmc_masked_clear_bank
    import pmc_clr_pkg::*;
#(
    parameter int NUM_EVT   = 31,
    parameter bit HAS_INSTR = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     wr_allowed,
    input  logic [MASK_W-1:0]        wr_mask,
    input  logic [NUM_EVT-1:0]       evt_en,
    input  logic [NUM_EVT-1:0]       evt_in,
    input  logic                     cyc_en,
    input  logic                     instr_en,
    input  logic                     instr_in,
    output logic [NUM_EVT*CNT_W-1:0] evt_cnt,
    output logic [CNT_W-1:0]         cyc_cnt,
    output logic [CNT_W-1:0]         instr_cnt
);
    clr_sel_t clr;

    pmc_clr_decode #(.NUM_EVT(NUM_EVT), .HAS_INSTR(HAS_INSTR)) u_decode (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_allowed(wr_allowed),
        .wr_mask(wr_mask), .clr(clr)
    );

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        pmc_counter u_cnt (
            .clk(clk), .rst(rst), .clr(clr.evt[i]), .en(evt_en[i]),
            .evt(evt_in[i]), .cnt(evt_cnt[i*CNT_W +: CNT_W])
        );
    end

    if (NUM_EVT < MAX_EVT) begin : g_evt_spare
        logic unused_evt_sel;
        assign unused_evt_sel = ^clr.evt[MAX_EVT-1:NUM_EVT];
    end

    pmc_counter u_cyc (
        .clk(clk), .rst(rst), .clr(clr.cyc), .en(cyc_en),
        .evt(1'b1), .cnt(cyc_cnt)
    );

    if (HAS_INSTR) begin : g_instr
        pmc_counter u_instr (
            .clk(clk), .rst(rst), .clr(clr.instr), .en(instr_en),
            .evt(instr_in), .cnt(instr_cnt)
        );
    end else begin : g_no_instr
        logic unused_instr;
        assign unused_instr = instr_en ^ instr_in ^ clr.instr;
        assign instr_cnt    = '0;
    end
endmodule

// File: tb/pmc_masked_clear_bank_bench.sv
module pmc_masked_clear_bank_bench;
    localparam int NE = 6;
    localparam int W  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, wr_allowed = 1'b0;
    logic [63:0] wr_mask = '0;
    logic [NE-1:0] evt_en = '0, evt_in = '0;
    logic cyc_en = 1'b0, instr_en = 1'b0, instr_in = 1'b0;
    logic [NE*W-1:0] evt_cnt;
    logic [W-1:0] cyc_cnt, instr_cnt;
    logic [2*W-1:0] n_evt_cnt;
    logic [W-1:0] n_cyc_cnt, n_instr_cnt;

    int checks = 0, fails = 0;
    logic [W-1:0] m_evt [NE];
    logic [W-1:0] m_cyc, m_instr;
    string phase = "R1";

    always #4 clk = ~clk;

    pmc_masked_clear_bank #(.NUM_EVT(NE), .HAS_INSTR(1'b1)) u_pmc_masked_clear_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_allowed(wr_allowed),
        .wr_mask(wr_mask), .evt_en(evt_en), .evt_in(evt_in), .cyc_en(cyc_en),
        .instr_en(instr_en), .instr_in(instr_in), .evt_cnt(evt_cnt),
        .cyc_cnt(cyc_cnt), .instr_cnt(instr_cnt)
    );

    pmc_masked_clear_bank #(.NUM_EVT(2), .HAS_INSTR(1'b0)) u_pmc_masked_clear_bank_noinstr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_allowed(wr_allowed),
        .wr_mask(wr_mask), .evt_en(evt_en[1:0]), .evt_in(evt_in[1:0]), .cyc_en(cyc_en),
        .instr_en(instr_en), .instr_in(instr_in), .evt_cnt(n_evt_cnt),
        .cyc_cnt(n_cyc_cnt), .instr_cnt(n_instr_cnt)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected next state from the requirements
    function automatic logic [W-1:0] nxt(input logic [W-1:0] cur, input logic sel, input logic inc);
        if (sel) return '0;          // R5 R6 R7 R11
        if (inc) return cur + 64'd1; // R2 R3 R4
        return cur;                  // R9
    endfunction

    task automatic check_all();
        for (int i = 0; i < NE; i++)
            chk({phase, " R2 R5 R9 evt"}, evt_cnt[i*W +: W], m_evt[i]);
        chk({phase, " R3 R6 cyc"}, cyc_cnt, m_cyc);
        chk({phase, " R4 R7 instr"}, instr_cnt, m_instr);
        chk({phase, " R4 R8 no-instr bank"}, n_instr_cnt, '0);
    endtask

    // Apply inputs at a negedge, update model, check at the next negedge
    task automatic step(input logic we, input logic wa, input logic [63:0] mk,
                        input logic [NE-1:0] en, input logic [NE-1:0] ev,
                        input logic ce, input logic ie, input logic ii);
        logic acc;
        wr_en = we; wr_allowed = wa; wr_mask = mk;
        evt_en = en; evt_in = ev; cyc_en = ce; instr_en = ie; instr_in = ii;
        acc = we & wa; // R10
        for (int i = 0; i < NE; i++) m_evt[i] = nxt(m_evt[i], acc & mk[i], en[i] & ev[i]);
        m_cyc   = nxt(m_cyc, acc & mk[31], ce);
        m_instr = nxt(m_instr, acc & mk[32], ie & ii);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NE; i++) m_evt[i] = '0;
        m_cyc = '0; m_instr = '0;
        evt_en = '1; evt_in = '1; cyc_en = 1'b1; instr_en = 1'b1; instr_in = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        phase = "R1";
        check_all();

        // Build counts
        phase = "R2 R3 R4";
        repeat (5) step(0, 0, '0, '1, '1, 1, 1, 1);
        step(0, 0, '0, 6'b101010, 6'b011011, 1, 1, 0);

        // Write strobed but not permitted, and permitted but not strobed
        phase = "R10";
        step(1, 0, '1, '1, '1, 1, 1, 1);
        step(0, 1, '1, '0, '0, 0, 0, 0);

        // Reserved bits and unimplemented event bits only
        phase = "R8";
        step(1, 1, 64'hFFFF_FFFE_0000_0000, '0, '0, 0, 0, 0);
        step(1, 1, 64'h0000_0000_7FFF_FFC0, '1, '1, 1, 1, 1);

        // Clear some counters while all increment: clear wins
        phase = "R11 R5 R9";
        step(1, 1, 64'h0000_0000_0000_0015, '1, '1, 1, 1, 1);
        phase = "R6";
        step(1, 1, 64'h0000_0000_8000_0000, '1, '1, 1, 1, 1);
        phase = "R7";
        step(1, 1, 64'h0000_0001_0000_0000, '1, '1, 1, 1, 1);
        phase = "R4 R8 bit32 no-instr";
        step(1, 1, 64'h0000_0001_0000_0000, '0, '0, 0, 1, 1);
        phase = "R11 all";
        step(1, 1, '1, '1, '1, 1, 1, 1);
        step(0, 0, '0, '1, '1, 1, 1, 1);

        // Random mix
        phase = "random";
        for (int k = 0; k < 400; k++) begin
            logic [63:0] mk;
            logic sel;
            mk  = {$urandom, $urandom} & {$urandom, $urandom};
            sel = ($urandom % 4) == 0;
            step(sel | ($urandom % 8 == 0), sel | ($urandom % 8 == 0), mk,
                 NE'($urandom), NE'($urandom | $urandom),
                 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // Reset mid-run
        phase = "R1 mid";
        rst = 1'b1;
        for (int i = 0; i < NE; i++) m_evt[i] = '0;
        m_cyc = '0; m_instr = '0;
        @(negedge clk);
        rst = 1'b0;
        check_all();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule